// File: doc/BRIEF.md
# Output Channel Power Sequencer

This block sits on the host side of a multi-channel converter that is configured over a serial register link. For every output channel it holds a shadow copy of that channel's 9-bit DAC-control word. It turns channels on and off by rewriting that word in 24-bit frames, which it hands to an SPI master over a valid/ready handshake. The SPI shifting itself belongs to the master, not to this block.

Powering a channel down takes one frame. That frame clears the internal-circuit enable, the output enable and the DC-DC enable together. Powering a channel up takes two frames. The first frame sets the internal-circuit enable and the DC-DC enable. The block then waits a settle interval, counted in system clocks from the clock frequency and a time in microseconds. The second frame then sets the output enable.

A request that asks for the state a channel already has is accepted and dropped without any frame. Only one sequence runs at a time. A mask of powered-down channels is always visible on the ports. All channels start out powered down.

Top module: `chan_power_seq`

## Requirements
- R1: After reset, `pdMask` is all ones, `reqReady` is 1 and `frmValid` is 0.
- R2: Every frame has the value 0x1C plus the channel number in bits 23:16 and the constant 2 in bits 15:13. Bits 12:9 are zero and bits 8:0 carry the channel's shadow word. In the shadow word, bit 8 is the internal-circuit enable, bit 7 the clear enable, bit 6 the output enable, bit 5 the internal sense-resistor select, bit 4 the DC-DC enable, bit 3 the overrange enable, and bits 2:0 the output mode.
- R3: When a power-up request is accepted, the first frame is driven one cycle later. It carries the shadow word with bits 8 and 4 set, bit 6 still clear, and every other bit kept.
- R4: The second power-up frame is driven exactly SETTLE_CYC cycles after the clock edge that accepted the first frame, where SETTLE_CYC = CLK_HZ/1000*SETTLE_US/1000 (at least 1). It equals the first frame with bit 6 also set.
- R5: A power-down request produces exactly one frame. That frame carries the shadow word with bits 8, 6 and 4 cleared and all other bits kept.
- R6: A request whose direction (`reqDown`) equals the channel's current `pdMask` bit produces no frame and leaves `pdMask` unchanged.
- R7: While `frmValid` is high and `frmReady` is low, `frmValid` stays high and `frmData` holds its value.
- R8: `reqReady` is low from the acceptance of a request that starts a sequence until the last frame of that sequence is accepted. A `reqValid` raised in that time is ignored and produces no frame.
- R9: A channel's `pdMask` bit changes on the clock edge at which the last frame of its sequence is accepted, and at no other time. At most one bit changes per cycle.
- R10: The shadow reset value is INIT_CTRL with bits 8, 6 and 4 forced to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Power request present |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqChan | input | CHAN_W | Channel addressed by the request |
| reqDown | input | 1 | 1 requests power-down, 0 requests power-up |
| frmValid | output | 1 | Frame on `frmData` is valid |
| frmReady | input | 1 | SPI master takes the frame |
| frmData | output | 24 | Register write frame for the SPI master |
| pdMask | output | NUM_CH | One bit per channel, set while the channel is powered down |

## Verification
Timing is as follows:
- A request taken on one edge drives its first frame from that edge, so the bench samples the frame at the next falling edge.
- `pdMask` moves on the edge that accepts the final frame and is checked half a cycle later.
- The second power-up frame appears SETTLE_CYC edges after the first frame is accepted. The bench counts edges from that acceptance until `frmValid` returns and compares the count with the exact value.

Backpressure of zero to three cycles is applied before every acceptance, and requests are pushed in during the stall. The bench checks that `frmData` holds and that no extra frame follows. A redundant request is watched for three cycles for the absence of a frame.

// File: rtl/chan_power_pkg.sv
package chan_power_pkg;

  localparam int CTRL_W  = 9;
  localparam int FRAME_W = 24;

  localparam int BIT_INT  = 8;
  localparam int BIT_OUT  = 6;
  localparam int BIT_DCDC = 4;

  localparam logic [7:0] CTRL_ADDR_BASE = 8'h1C;
  localparam logic [2:0] SUBREG_DAC     = 3'd2;

  localparam logic [CTRL_W-1:0] PWR_BITS =
    CTRL_W'((1 << BIT_INT) | (1 << BIT_OUT) | (1 << BIT_DCDC));
  localparam logic [CTRL_W-1:0] EN_BITS =
    CTRL_W'((1 << BIT_INT) | (1 << BIT_DCDC));
  localparam logic [CTRL_W-1:0] OUT_BIT = CTRL_W'(1 << BIT_OUT);

  typedef enum logic [2:0] {
    S_IDLE,
    S_DOWN,
    S_EN,
    S_SETTLE,
    S_OUT
  } seqState_t;

  typedef struct packed {
    logic takeReq;
    logic setEnable;
    logic setOutput;
    logic clearAll;
    logic markUp;
    logic markDown;
  } seqStrobe_t;

endpackage

// File: rtl/chan_power_ctrl.sv
module chan_power_ctrl
  import chan_power_pkg::*;
#(
  parameter int SETTLE_CYC = 10000,
  localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqDown,
  input  logic       chanIsDown,
  input  logic       frmReady,
  output logic       reqReady,
  output logic       frmValid,
  output seqStrobe_t strobe
);

  seqState_t  state, nextState;
  logic [CNT_W-1:0] settleCnt;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (reqValid && (reqDown != chanIsDown)) begin
          strobe.takeReq = 1'b1;
          if (reqDown) begin
            strobe.clearAll = 1'b1;
            nextState       = S_DOWN;
          end else begin
            strobe.setEnable = 1'b1;
            nextState        = S_EN;
          end
        end
      end
      S_DOWN: begin
        if (frmReady) begin
          strobe.markDown = 1'b1;
          nextState       = S_IDLE;
        end
      end
      S_EN: begin
        if (frmReady) nextState = S_SETTLE;
      end
      S_SETTLE: begin
        if (settleCnt == '0) begin
          strobe.setOutput = 1'b1;
          nextState        = S_OUT;
        end
      end
      S_OUT: begin
        if (frmReady) begin
          strobe.markUp = 1'b1;
          nextState     = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign reqReady = (state == S_IDLE);
  assign frmValid = (state == S_DOWN) || (state == S_EN) || (state == S_OUT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      state <= nextState;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (state == S_EN && frmReady) begin
      settleCnt <= CNT_W'(SETTLE_CYC - 1);
    end else if (state == S_SETTLE && settleCnt != '0) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end

endmodule

// File: rtl/chan_power_dp.sv
module chan_power_dp
  import chan_power_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter logic [CTRL_W-1:0] INIT_CTRL = 9'h024,
  localparam int CHAN_W = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [CHAN_W-1:0]  reqChan,
  output logic               chanIsDown,
  output logic [FRAME_W-1:0] frmData,
  output logic [NUM_CH-1:0]  pdMask
);

  localparam logic [CTRL_W-1:0] SHADOW_RST = INIT_CTRL & ~PWR_BITS;
  localparam int PAD_W = FRAME_W - 8 - 3 - CTRL_W;

  logic [CHAN_W-1:0] curChan;
  logic [CHAN_W-1:0] tgtChan;
  logic [CTRL_W-1:0] shadow [NUM_CH];

  assign tgtChan = strobe.takeReq ? reqChan : curChan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curChan <= '0;
    end else if (strobe.takeReq) begin
      curChan <= reqChan;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic hit;
    assign hit = (tgtChan == CHAN_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadow[g] <= SHADOW_RST;
      end else if (hit) begin
        if (strobe.clearAll)       shadow[g] <= shadow[g] & ~PWR_BITS;
        else if (strobe.setEnable) shadow[g] <= shadow[g] | EN_BITS;
        else if (strobe.setOutput) shadow[g] <= shadow[g] | OUT_BIT;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pdMask[g] <= 1'b1;
      end else if (hit && strobe.markDown) begin
        pdMask[g] <= 1'b1;
      end else if (hit && strobe.markUp) begin
        pdMask[g] <= 1'b0;
      end
    end
  end

  assign chanIsDown = pdMask[reqChan];
  assign frmData    = {CTRL_ADDR_BASE + 8'(curChan), SUBREG_DAC,
                       {PAD_W{1'b0}}, shadow[curChan]};

endmodule

// File: rtl/chan_power_seq.sv
module chan_power_seq
  import chan_power_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CLK_HZ    = 50_000_000,
  parameter int SETTLE_US = 200,
  parameter logic [8:0] INIT_CTRL = 9'h024,
  localparam int CHAN_W     = $clog2(NUM_CH),
  localparam int SETTLE_RAW = CLK_HZ / 1000 * SETTLE_US / 1000,
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic              reqDown,
  output logic              frmValid,
  input  logic              frmReady,
  output logic [23:0]       frmData,
  output logic [NUM_CH-1:0] pdMask
);

  seqStrobe_t strobe;
  logic       chanIsDown;

  chan_power_ctrl #(
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqDown   (reqDown),
    .chanIsDown(chanIsDown),
    .frmReady  (frmReady),
    .reqReady  (reqReady),
    .frmValid  (frmValid),
    .strobe    (strobe)
  );

  chan_power_dp #(
    .NUM_CH   (NUM_CH),
    .INIT_CTRL(INIT_CTRL)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqChan   (reqChan),
    .chanIsDown(chanIsDown),
    .frmData   (frmData),
    .pdMask    (pdMask)
  );

endmodule

// File: rtl/chan_power_seq_chk.sv
module chan_power_seq_chk #(
  parameter int NUM_CH    = 4,
  parameter int CLK_HZ    = 50_000_000,
  parameter int SETTLE_US = 200,
  localparam int SETTLE_RAW = CLK_HZ / 1000 * SETTLE_US / 1000,
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW,
  localparam int GAP_W      = $clog2(SETTLE_CYC + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              frmValid,
  input logic              frmReady,
  input logic [23:0]       frmData,
  input logic [NUM_CH-1:0] pdMask
);

  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (frmValid && frmReady) begin
      gapCnt <= '0;
    end else if (gapCnt < GAP_W'(SETTLE_CYC)) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  assert_frame_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !frmReady) |=> (frmValid && $stable(frmData)));

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && frmValid));

  assert_frame_header_R2: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |-> (frmData[15:13] == 3'd2 && frmData[12:9] == 4'd0));

  assert_settle_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(frmValid) && frmData[6]) |-> (gapCnt >= GAP_W'(SETTLE_CYC)));

  assert_mask_on_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pdMask != $past(pdMask)) |-> $past(frmValid && frmReady));

  assert_mask_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pdMask ^ $past(pdMask)) <= 1);

endmodule

bind chan_power_seq chan_power_seq_chk #(
  .NUM_CH   (NUM_CH),
  .CLK_HZ   (CLK_HZ),
  .SETTLE_US(SETTLE_US)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .frmValid(frmValid),
  .frmReady(frmReady),
  .frmData (frmData),
  .pdMask  (pdMask)
);

// File: tb/chan_power_seq_bench.sv
module chan_power_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 4;
  localparam int CLK_HZ     = 1_000_000;
  localparam int SETTLE_US  = 200;
  localparam int SETTLE     = CLK_HZ / 1000 * SETTLE_US / 1000;
  localparam logic [8:0] INIT = 9'h0AD;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqChan = '0;
  logic        reqDown = 1'b0;
  logic        frmValid;
  logic        frmReady = 1'b0;
  logic [23:0] frmData;
  logic [3:0]  pdMask;

  int checks = 0;
  int errors = 0;

  logic [8:0] mdlShadow [NUM_CH];
  logic [3:0] mdlPd;

  always #(CLK_PERIOD / 2) clk = ~clk;

  chan_power_seq #(
    .NUM_CH   (NUM_CH),
    .CLK_HZ   (CLK_HZ),
    .SETTLE_US(SETTLE_US),
    .INIT_CTRL(INIT)
  ) u_chan_power_seq (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .reqChan (reqChan),
    .reqDown (reqDown),
    .frmValid(frmValid),
    .frmReady(frmReady),
    .frmData (frmData),
    .pdMask  (pdMask)
  );

  function automatic logic [23:0] frameOf(input int ch, input logic [8:0] w);
    return {8'h1C + 8'(ch), 3'd2, 4'd0, w};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic handshake(input int ch, input logic [23:0] exp, input string tag);
    int k;
    check(frmValid === 1'b1 && frmData === exp, tag, {8'd0, frmData}, {8'd0, exp});
    check(frmData[23:13] === {8'h1C + 8'(ch), 3'd2}, "R2",
          {21'd0, frmData[23:13]}, {21'd0, 8'h1C + 8'(ch), 3'd2});
    k = $urandom % 4;
    for (int i = 0; i < k; i++) begin
      frmReady = 1'b0;
      reqValid = 1'b1;
      reqChan  = 2'($urandom % 4);
      reqDown  = 1'($urandom % 2);
      @(posedge clk);
      @(negedge clk);
      check(frmValid === 1'b1 && frmData === exp, "R7", {8'd0, frmData}, {8'd0, exp});
      check(reqReady === 1'b0, "R8", {31'd0, reqReady}, 32'd0);
    end
    reqValid = 1'b0;
    frmReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frmReady = 1'b0;
  endtask

  task automatic doReq(input int ch, input bit down);
    int n;
    check(reqReady === 1'b1, "R8", {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1;
    reqChan  = 2'(ch);
    reqDown  = down;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (down == mdlPd[ch]) begin
      for (int i = 0; i < 3; i++) begin
        check(frmValid === 1'b0, "R6", {31'd0, frmValid}, 32'd0);
        @(posedge clk);
        @(negedge clk);
      end
      check(pdMask === mdlPd, "R6", {28'd0, pdMask}, {28'd0, mdlPd});
    end else if (down) begin
      mdlShadow[ch] = mdlShadow[ch] & ~9'h150;
      handshake(ch, frameOf(ch, mdlShadow[ch]), "R5");
      mdlPd[ch] = 1'b1;
      check(pdMask === mdlPd, "R9", {28'd0, pdMask}, {28'd0, mdlPd});
      check(frmValid === 1'b0, "R5", {31'd0, frmValid}, 32'd0);
    end else begin
      mdlShadow[ch] = mdlShadow[ch] | 9'h110;
      handshake(ch, frameOf(ch, mdlShadow[ch]), "R3");
      n = 0;
      while (frmValid !== 1'b1 && n < SETTLE + 10) begin
        check(pdMask === mdlPd && reqReady === 1'b0, "R9", {28'd0, pdMask}, {28'd0, mdlPd});
        @(posedge clk);
        @(negedge clk);
        n++;
      end
      check(n == SETTLE, "R4", n, SETTLE);
      mdlShadow[ch] = mdlShadow[ch] | 9'h040;
      handshake(ch, frameOf(ch, mdlShadow[ch]), "R4");
      mdlPd[ch] = 1'b0;
      check(pdMask === mdlPd, "R9", {28'd0, pdMask}, {28'd0, mdlPd});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    for (int c = 0; c < NUM_CH; c++) mdlShadow[c] = INIT & ~9'h150;
    mdlPd = 4'hF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(pdMask === 4'hF, "R1", {28'd0, pdMask}, 32'hF);
    check(reqReady === 1'b1 && frmValid === 1'b0, "R1",
          {30'd0, reqReady, frmValid}, 32'd2);

    // R10: first power-up frame reveals the reset shadow of channel 0
    doReq(0, 1'b0);
    doReq(0, 1'b0);
    doReq(0, 1'b1);
    doReq(3, 1'b1);
    doReq(3, 1'b0);
    doReq(2, 1'b0);
    doReq(3, 1'b1);
    for (int i = 0; i < 40; i++) doReq($urandom % 4, 1'($urandom % 2));
    check(pdMask === mdlPd, "R9", {28'd0, pdMask}, {28'd0, mdlPd});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule